// File: doc/BRIEF.md
# Three-Channel Video Range Rescaler

This block stretches each of three video channels from a reduced code range (for example studio-range luma or chroma) onto the full input scale of a downstream converter. Every channel has its own settings and is handled on its own. A sample is first optionally clamped between a low and a high code. A shift is then subtracted from it, and the result is multiplied by an unsigned gain below 2. The output is 11 bits wide against a 10-bit input. The extra bit is one fractional bit relative to the input scale, so the rounding step that follows the gain does not throw away resolution.

Samples enter with a valid strobe and leave two clocks later, with the strobe delayed alongside them. All clamp, shift and gain settings are static per-channel inputs. Turning the clamp off lets super-white and super-black excursions through to the shift and gain stages.

Top module: `chan_rescale`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is all zeros.
- R2: valid_o equals valid_i from two rising clock edges earlier, and the result for a sample taken with valid_i high appears on data_o after that same second edge.
- R3: With clamping enabled for a channel, its input x is replaced by min(max(x, low), high) before the shift.
- R4: With clamping disabled for a channel, its input reaches the shift stage unchanged, including codes above its high setting.
- R5: The shift is subtracted from the clamped value, and a result below zero becomes 0.
- R6: The gain is unsigned fixed point, 1 integer and 10 fractional bits (0 to 2047/1024). The output equals floor((s*g + 256) / 512), where s is the shifted value and g is the gain code. An exact half therefore rounds up.
- R7: Channel c uses bits [10c+9:10c] of data_i, clip_lo_i, clip_hi_i and shift_i, bit c of clip_en_i, bits [11c+10:11c] of gain_i, and drives bits [11c+10:11c] of data_o. The channels do not affect one another.
- R8: data_o holds its last value on every cycle where valid_o is low, whatever data_i does.
- R9: With clamp 64..940, shift 64 and gain 1196 on a channel, input 64 gives 0 and input 940 gives a code within 1 of 2047.
- R10: A result above 2047 is saturated to 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 30 | Three 10-bit input samples, channel 0 in the low bits |
| clip_en_i | input | 3 | Clamp enable per channel |
| clip_lo_i | input | 30 | Low clamp code per channel |
| clip_hi_i | input | 30 | High clamp code per channel |
| shift_i | input | 30 | Subtracted offset per channel |
| gain_i | input | 33 | 1.10 fixed-point gain per channel |
| valid_o | output | 1 | Output sample strobe |
| data_o | output | 33 | Three 11-bit results, channel 0 in the low bits |

## Verification
The bench builds the block with its default parameters: three channels, 10-bit inputs, 11-bit outputs and an 11-bit gain with 10 fractional bits. This leaves nine product bits to round away. With these widths the largest product (1023 times 2047) maps to 4090, so the saturation path can be reached. A gain of 256 applied to a value of 1 lands exactly on a rounding tie. Studio luma and chroma settings are driven alongside bypassed clamps, zero gain and mixed per-channel settings. A long run with random strobes and settings is then compared against a behavioural reference on every clock.

// File: rtl/rescale_pkg.sv
package rescale_pkg;
  localparam int unsigned CH_N_DEF      = 3;
  localparam int unsigned IN_W_DEF      = 10;
  localparam int unsigned OUT_W_DEF     = 11;
  localparam int unsigned GAIN_W_DEF    = 11;
  localparam int unsigned GAIN_FRAC_DEF = 10;
endpackage

// File: rtl/rescale_clip_shift.sv
module rescale_clip_shift #(
  parameter int unsigned IN_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clip_en_i,
  input  logic [IN_W-1:0] x_i,
  input  logic [IN_W-1:0] lo_i,
  input  logic [IN_W-1:0] hi_i,
  input  logic [IN_W-1:0] shift_i,
  output logic [IN_W-1:0] s_o
);
  logic [IN_W-1:0] above_lo, clamped, shifted;

  always_comb begin
    above_lo = (x_i < lo_i) ? lo_i : x_i;
    clamped  = clip_en_i ? ((above_lo > hi_i) ? hi_i : above_lo) : x_i;
    // negative differences floor at zero
    shifted  = (clamped >= shift_i) ? (clamped - shift_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   s_o <= '0;
    else if (en_i) s_o <= shifted;
  end
endmodule

// File: rtl/rescale_gain.sv
module rescale_gain #(
  parameter int unsigned IN_W   = 10,
  parameter int unsigned GAIN_W = 11,
  parameter int unsigned OUT_W  = 11,
  parameter int unsigned DROP   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IN_W-1:0]   s_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [OUT_W-1:0]  y_o
);
  localparam int unsigned PROD_W   = IN_W + GAIN_W;
  localparam int unsigned SCALED_W = PROD_W - DROP;
  localparam logic [PROD_W-1:0] BIAS = PROD_W'(1) << (DROP - 1);

  logic [PROD_W-1:0]   prod, rounded;
  logic [SCALED_W-1:0] scaled;
  logic [OUT_W-1:0]    sat;

  always_comb begin
    prod    = PROD_W'(s_i) * PROD_W'(gain_i);
    rounded = prod + BIAS;
    scaled  = rounded[PROD_W-1:DROP];
  end

  generate
    if (SCALED_W > OUT_W) begin : g_sat
      always_comb sat = (|scaled[SCALED_W-1:OUT_W]) ? '1 : scaled[OUT_W-1:0];
    end else begin : g_nosat
      always_comb sat = OUT_W'(scaled);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= sat;
  end
endmodule

// File: rtl/chan_rescale.sv
module chan_rescale
  import rescale_pkg::*;
#(
  parameter int unsigned CH_N      = CH_N_DEF,
  parameter int unsigned IN_W      = IN_W_DEF,
  parameter int unsigned OUT_W     = OUT_W_DEF,
  parameter int unsigned GAIN_W    = GAIN_W_DEF,
  parameter int unsigned GAIN_FRAC = GAIN_FRAC_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [CH_N*IN_W-1:0]     data_i,
  input  logic [CH_N-1:0]          clip_en_i,
  input  logic [CH_N*IN_W-1:0]     clip_lo_i,
  input  logic [CH_N*IN_W-1:0]     clip_hi_i,
  input  logic [CH_N*IN_W-1:0]     shift_i,
  input  logic [CH_N*GAIN_W-1:0]   gain_i,
  output logic                     valid_o,
  output logic [CH_N*OUT_W-1:0]    data_o
);
  // output carries (OUT_W-IN_W) fraction bits relative to the input scale
  localparam int unsigned DROP = GAIN_FRAC - (OUT_W - IN_W);

  logic valid_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_s1 <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_s1 <= valid_i;
      valid_o  <= valid_s1;
    end
  end

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic [IN_W-1:0] s1;

      rescale_clip_shift #(.IN_W(IN_W)) u_cs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (valid_i),
        .clip_en_i (clip_en_i[c]),
        .x_i       (data_i[c*IN_W +: IN_W]),
        .lo_i      (clip_lo_i[c*IN_W +: IN_W]),
        .hi_i      (clip_hi_i[c*IN_W +: IN_W]),
        .shift_i   (shift_i[c*IN_W +: IN_W]),
        .s_o       (s1)
      );

      rescale_gain #(
        .IN_W(IN_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .DROP(DROP)
      ) u_gain (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (valid_s1),
        .s_i    (s1),
        .gain_i (gain_i[c*GAIN_W +: GAIN_W]),
        .y_o    (data_o[c*OUT_W +: OUT_W])
      );
    end
  endgenerate
endmodule

// File: rtl/chan_rescale_chk.sv
module chan_rescale_chk #(
  parameter int unsigned CH_N   = 3,
  parameter int unsigned IN_W   = 10,
  parameter int unsigned OUT_W  = 11,
  parameter int unsigned GAIN_W = 11
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [CH_N*IN_W-1:0]   data_i,
  input logic [CH_N-1:0]        clip_en_i,
  input logic [CH_N*IN_W-1:0]   shift_i,
  input logic [CH_N*GAIN_W-1:0] gain_i,
  input logic                   valid_o,
  input logic [CH_N*OUT_W-1:0]  data_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!valid_o && data_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !valid_o) |-> $stable(data_o));

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      p_zero_gain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc >= 2'd1 && valid_o && $past(gain_i[c*GAIN_W +: GAIN_W]) == '0)
        |-> (data_o[c*OUT_W +: OUT_W] == '0));

      p_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc >= 2'd2 && valid_o &&
         $past(!clip_en_i[c] && (data_i[c*IN_W +: IN_W] <= shift_i[c*IN_W +: IN_W]), 2))
        |-> (data_o[c*OUT_W +: OUT_W] == '0));
    end
  endgenerate
endmodule

bind chan_rescale chan_rescale_chk #(
  .CH_N(CH_N), .IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .data_i    (data_i),
  .clip_en_i (clip_en_i),
  .shift_i   (shift_i),
  .gain_i    (gain_i),
  .valid_o   (valid_o),
  .data_o    (data_o)
);

// File: tb/chan_rescale_test.sv
module chan_rescale_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vin;
  logic [29:0] din, lo, hi, sh;
  logic [2:0]  cen;
  logic [32:0] gn;
  logic        vout;
  logic [32:0] dout;

  always #10 clk = ~clk;

  chan_rescale uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din),
    .clip_en_i(cen), .clip_lo_i(lo), .clip_hi_i(hi), .shift_i(sh),
    .gain_i(gn), .valid_o(vout), .data_o(dout)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_s1[3];
  int m_out[3];
  bit m_v1, m_vo;

  function automatic int ref_front(int x, int l, int h, int s, bit ce);
    int v = x;
    if (ce) begin
      if (v < l) v = l;
      if (v > h) v = h;
    end
    v = v - s;
    if (v < 0) v = 0;
    return v;
  endfunction

  function automatic int ref_back(int s, int g);
    int r = (s * g + 256) / 512;
    if (r > 2047) r = 2047;
    return r;
  endfunction

  function automatic int out_ch(int c);
    return int'(dout[c*11 +: 11]);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ch(int c, bit ce, int l, int h, int s, int g);
    cen[c]          = ce;
    lo[c*10 +: 10]  = 10'(l);
    hi[c*10 +: 10]  = 10'(h);
    sh[c*10 +: 10]  = 10'(s);
    gn[c*11 +: 11]  = 11'(g);
  endtask

  // drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(bit v, int d0, int d1, int d2);
    vin = v;
    din = {10'(d2), 10'(d1), 10'(d0)};
    @(posedge clk);
    if (m_v1)
      for (int c = 0; c < 3; c++) m_out[c] = ref_back(m_s1[c], int'(gn[c*11 +: 11]));
    m_vo = m_v1;
    if (v)
      for (int c = 0; c < 3; c++)
        m_s1[c] = ref_front(int'(din[c*10 +: 10]), int'(lo[c*10 +: 10]),
                            int'(hi[c*10 +: 10]), int'(sh[c*10 +: 10]), cen[c]);
    m_v1 = v;
    @(negedge clk);
    check("R2 valid_o", int'(vout), int'(m_vo));
    for (int c = 0; c < 3; c++) check("R6 data_o vs model", out_ch(c), m_out[c]);
  endtask

  task automatic studio_cfg();
    set_ch(0, 1'b1, 64, 940, 64, 1196);
    set_ch(1, 1'b1, 64, 960, 64, 1169);
    set_ch(2, 1'b1, 64, 960, 64, 1169);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int held[3];
    rst_n = 1'b1;
    vin = 1'b0; din = '0; cen = '0; lo = '0; hi = '0; sh = '0; gn = '0;
    for (int c = 0; c < 3; c++) begin m_s1[c] = 0; m_out[c] = 0; end
    m_v1 = 0; m_vo = 0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid_o", int'(vout), 0);
    check("R1 reset data_o", int'(dout != '0), 0);
    rst_n = 1'b1;

    // R9 studio ranges
    studio_cfg();
    step(1'b1, 64, 960, 512);
    step(1'b0, 0, 0, 0);
    check("R9 luma black", out_ch(0), 0);
    check("R9 chroma top", out_ch(1), 2046);
    check("R9 chroma mid", out_ch(2), 1023);
    step(1'b1, 940, 64, 960);
    step(1'b0, 0, 0, 0);
    check("R9 luma white", out_ch(0), 2046);
    check("R9 chroma black", out_ch(1), 0);

    // R3 clamp active
    step(1'b1, 1000, 10, 1023);
    step(1'b0, 0, 0, 0);
    check("R3 clamp high ch0", out_ch(0), 2046);
    check("R3 clamp low ch1", out_ch(1), 0);
    check("R3 clamp high ch2", out_ch(2), 2046);

    // R4 bypass, R5 floor, R10 saturation
    set_ch(0, 1'b0, 64, 940, 64, 1024);
    set_ch(1, 1'b0, 64, 960, 64, 1024);
    set_ch(2, 1'b0, 64, 960, 0, 2047);
    step(1'b1, 1000, 10, 1023);
    step(1'b0, 0, 0, 0);
    check("R4 super-white passes", out_ch(0), 1872);
    check("R5 negative floors", out_ch(1), 0);
    check("R10 saturate", out_ch(2), 2047);

    // R7 independent gains
    set_ch(0, 1'b0, 0, 1023, 0, 0);
    set_ch(1, 1'b0, 0, 1023, 0, 1024);
    set_ch(2, 1'b0, 0, 1023, 0, 512);
    step(1'b1, 300, 300, 300);
    step(1'b0, 0, 0, 0);
    check("R7 ch0 gain zero", out_ch(0), 0);
    check("R7 ch1 unity", out_ch(1), 600);
    check("R7 ch2 half", out_ch(2), 300);

    // R6 rounding tie
    set_ch(0, 1'b0, 0, 1023, 0, 256);
    set_ch(1, 1'b0, 0, 1023, 0, 255);
    set_ch(2, 1'b0, 0, 1023, 0, 1024);
    step(1'b1, 1, 1, 1);
    step(1'b0, 0, 0, 0);
    check("R6 tie rounds up", out_ch(0), 1);
    check("R6 below tie", out_ch(1), 0);
    check("R6 unity one", out_ch(2), 2);

    // R8 hold while idle
    for (int c = 0; c < 3; c++) held[c] = out_ch(c);
    for (int i = 0; i < 3; i++) step(1'b0, 1023 - i, 500 + i, i);
    for (int c = 0; c < 3; c++) check("R8 hold", out_ch(c), held[c]);

    // random run against the model
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0)
        for (int c = 0; c < 3; c++)
          set_ch(c, 1'($urandom), int'($urandom % 512), 512 + int'($urandom % 512),
                 int'($urandom % 256), int'($urandom % 2048));
      step(1'($urandom), int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule